// File: doc/BRIEF.md
# Ring Loop Repeater with Go-Ahead Capture

This block is the serial transmit controller of one station on a ring of stations. Each bit that arrives from the upstream neighbour passes through a short delay line and leaves on the transmit output, so the ring keeps running whether or not the station has anything to say. One bit is handled per clock cycle.

When the mode field selects loop operation, the transmitter is enabled and a local frame is pending, the controller arms and watches the received stream for the go-ahead token: a 0 followed by seven 1s, on any bit boundary. The token's last 1 is still inside the delay line when the token is recognised, so it is overwritten with a 0. The token leaves as a flag and the ring sees no break. Straight after that flag the controller pulls bits, one per cycle, from a bit-stuffing frame source and sends them. After the bit the source marks as last, it sends a fresh go-ahead token so that downstream stations may transmit, and then it goes back to repeating.

A two-bit status output tells whether the controller is repeating, armed and waiting for the token, or sending.

Top module: `ring_loop_tx`

## Requirements
- R1: While reset is asserted and after its release, tx_out is 1, status is 2'b00 (repeating) and loc_req is 0.
- R2: While status is 2'b00 or 2'b01, tx_out equals rx_bit delayed by DELAY clock cycles (default 2). The received stream is forwarded unchanged except for the one bit named in R6.
- R3: From status 2'b00, status becomes 2'b01 one cycle after mode_code is 4'b1110, tx_en is 1 and frame_ready is 1 all at once. If any of the three is lost before the token is found, status returns to 2'b00 on the next cycle. Status never moves from 2'b00 straight to 2'b10.
- R4: Every mode_code other than 4'b1110 keeps the controller in status 2'b00, and a token in the received stream is then repeated unchanged.
- R5: The token is matched only while status is 2'b01, against the last eight received bits in arrival order: 0 followed by seven 1s. A run of 1s with no received 0 before it, including one that starts at reset, is not a match. A near miss such as 0,1,1,1,1,1,1,0 is not a match either.
- R6: When the token matches, its final 1 is sent as 0, so the outgoing bits read 0,1,1,1,1,1,1,0. Status reads 2'b10 from the cycle after the token's last bit was received.
- R7: While sending, loc_req is 1 in each cycle in which a local bit is taken. loc_bit taken in that cycle appears on tx_out after the next clock edge. The first local bit leaves in the bit time right after the flag's final 0, and loc_req is 0 in every other status.
- R8: After the local bit taken with loc_last = 1, the next eight output bits are 0 then seven 1s. Then status becomes 2'b00 and R2 repeating resumes.
- R9: While status is 2'b10, the received bits, tx_en, frame_ready and mode_code have no effect on tx_out or status until the go-ahead of R8 is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 4 | Transmit mode field; 4'b1110 selects loop operation |
| tx_en | input | 1 | Transmitter enable |
| frame_ready | input | 1 | A local frame is waiting to be sent |
| rx_bit | input | 1 | Serial bit from the upstream station |
| loc_bit | input | 1 | Next stuffed local bit, valid while loc_req is 1 |
| loc_last | input | 1 | loc_bit is the final bit of the frame, including its closing flag |
| loc_req | output | 1 | Local bit taken at the next clock edge |
| tx_out | output | 1 | Serial bit to the downstream station |
| status | output | 2 | 2'b00 repeating, 2'b01 waiting for token, 2'b10 sending |

## Verification
The bench feeds a token on the received line and checks the exact eight outgoing bits around it. A design that replaced the bit too late would let the token pass as an abort, and one that replaced it too early would break the preceding 1s. It also checks that the first local bit follows the flag with no gap and no repeated bit.

Long runs of 1s after reset, and a flag-shaped near miss, must not start a transmission. A detector with a zeroed history would fire on the first seven 1s. A token sent while a reserved mode code is selected must pass unchanged.

During a frame, the bench puts a token on the input and drops the enables. A design that kept searching or aborted would corrupt the local bits or the closing go-ahead.

// File: rtl/ring_loop_pkg.sv
`timescale 1ns/1ps
package ring_loop_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        S_REPEAT  = 3'd0,
        S_ARMED   = 3'd1,
        S_DRAIN   = 3'd2,
        S_SEND    = 3'd3,
        S_GOAHEAD = 3'd4
    } seq_state_e;

    // Externally visible status code
    typedef enum logic [1:0] {
        STAT_REPEAT = 2'b00,
        STAT_WAIT   = 2'b01,
        STAT_SEND   = 2'b10
    } loop_status_e;

    localparam logic [3:0] LOOP_MODE_CODE = 4'b1110;
    localparam int         TOKEN_LEN      = 8;
    // Oldest bit in the MSB: a 0 followed by seven 1s
    localparam logic [TOKEN_LEN-1:0] TOKEN_PATTERN = 8'b0111_1111;

endpackage

// File: rtl/ring_loop_tokdet.sv
`timescale 1ns/1ps
module ring_loop_tokdet #(
    parameter int                  TOK_LEN = 8,
    parameter logic [TOK_LEN-1:0]  TOK_PAT = 8'b0111_1111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    output logic tok_hit
);
    localparam int HIST_W = TOK_LEN - 1;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } tokdet_s;

    tokdet_s cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.hist = {cur_q.hist[HIST_W-2:0], rx_bit};
        // The window ends with the bit arriving in this cycle
        tok_hit    = ({cur_q.hist, rx_bit} == TOK_PAT);
    end

    // History resets to ones so no token can be seen before a real 0 arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{hist: '1};
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/ring_loop_dline.sv
`timescale 1ns/1ps
module ring_loop_dline #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic zero_in,
    input  logic ovr_en,
    input  logic ovr_bit,
    output logic out_bit
);
    typedef struct packed {
        logic [DELAY-1:0] stage;
    } dline_s;

    dline_s cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.stage[0] = zero_in ? 1'b0 : in_bit;
        for (int i = 1; i < DELAY; i++) begin
            nxt_d.stage[i] = cur_q.stage[i-1];
        end
        // The last stage is the line driver; local data enters there
        if (ovr_en) nxt_d.stage[DELAY-1] = ovr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{stage: '1};
        else        cur_q <= nxt_d;
    end

    assign out_bit = cur_q.stage[DELAY-1];

endmodule

// File: rtl/ring_loop_seq.sv
`timescale 1ns/1ps
module ring_loop_seq
    import ring_loop_pkg::*;
#(
    parameter int DELAY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_code,
    input  logic       tx_en,
    input  logic       frame_ready,
    input  logic       tok_hit,
    input  logic       loc_bit,
    input  logic       loc_last,
    output logic       capture,
    output logic       ovr_en,
    output logic       ovr_bit,
    output logic       loc_req,
    output logic [1:0] status
);
    localparam int CNT_W      = $clog2(DELAY + TOKEN_LEN);
    localparam int DRAIN_INIT = (DELAY > 1) ? DELAY - 2 : 0;
    localparam logic [CNT_W-1:0] GA_LAST = CNT_W'(TOKEN_LEN - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s cur_q, nxt_d;
    logic go;
    logic [TOKEN_LEN-1:0] ga_shift;

    always_comb begin
        nxt_d    = cur_q;
        capture  = 1'b0;
        ovr_en   = 1'b0;
        ovr_bit  = 1'b1;
        loc_req  = 1'b0;
        go       = (mode_code == LOOP_MODE_CODE) && tx_en && frame_ready;
        ga_shift = TOKEN_PATTERN << cur_q.cnt;

        unique case (cur_q.state)
            S_REPEAT: begin
                if (go) nxt_d.state = S_ARMED;
            end
            S_ARMED: begin
                if (!go) begin
                    nxt_d.state = S_REPEAT;
                end else if (tok_hit) begin
                    capture = 1'b1;
                    if (DELAY == 1) begin
                        nxt_d.state = S_SEND;
                    end else begin
                        nxt_d.state = S_DRAIN;
                        nxt_d.cnt   = CNT_W'(DRAIN_INIT);
                    end
                end
            end
            S_DRAIN: begin
                // Let the substituted flag bit reach the line driver
                if (cur_q.cnt == '0) nxt_d.state = S_SEND;
                else                 nxt_d.cnt   = cur_q.cnt - CNT_W'(1);
            end
            S_SEND: begin
                ovr_en  = 1'b1;
                ovr_bit = loc_bit;
                loc_req = 1'b1;
                if (loc_last) begin
                    nxt_d.state = S_GOAHEAD;
                    nxt_d.cnt   = '0;
                end
            end
            S_GOAHEAD: begin
                ovr_en  = 1'b1;
                ovr_bit = ga_shift[TOKEN_LEN-1];
                if (cur_q.cnt == GA_LAST) nxt_d.state = S_REPEAT;
                else                      nxt_d.cnt   = cur_q.cnt + CNT_W'(1);
            end
            default: nxt_d.state = S_REPEAT;
        endcase

        unique case (cur_q.state)
            S_REPEAT: status = STAT_REPEAT;
            S_ARMED:  status = STAT_WAIT;
            default:  status = STAT_SEND;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: S_REPEAT, cnt: '0};
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/ring_loop_tx.sv
`timescale 1ns/1ps
module ring_loop_tx
    import ring_loop_pkg::*;
#(
    parameter int DELAY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_code,
    input  logic       tx_en,
    input  logic       frame_ready,
    input  logic       rx_bit,
    input  logic       loc_bit,
    input  logic       loc_last,
    output logic       loc_req,
    output logic       tx_out,
    output logic [1:0] status
);
    logic tok_hit;
    logic capture;
    logic ovr_en;
    logic ovr_bit;

    ring_loop_tokdet #(
        .TOK_LEN (TOKEN_LEN),
        .TOK_PAT (TOKEN_PATTERN)
    ) tokdet_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_bit  (rx_bit),
        .tok_hit (tok_hit)
    );

    ring_loop_seq #(
        .DELAY (DELAY)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_code   (mode_code),
        .tx_en       (tx_en),
        .frame_ready (frame_ready),
        .tok_hit     (tok_hit),
        .loc_bit     (loc_bit),
        .loc_last    (loc_last),
        .capture     (capture),
        .ovr_en      (ovr_en),
        .ovr_bit     (ovr_bit),
        .loc_req     (loc_req),
        .status      (status)
    );

    ring_loop_dline #(
        .DELAY (DELAY)
    ) dline_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bit  (rx_bit),
        .zero_in (capture),
        .ovr_en  (ovr_en),
        .ovr_bit (ovr_bit),
        .out_bit (tx_out)
    );

endmodule

// File: rtl/ring_loop_tx_chk.sv
`timescale 1ns/1ps
module ring_loop_tx_chk
    import ring_loop_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_code,
    input logic       rx_bit,
    input logic       loc_req,
    input logic [1:0] status
);
    // R3: the controller never starts sending without first waiting for the token
    p_no_skip_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_REPEAT) |=> (status != STAT_SEND));

    // R4: a mode code other than loop keeps the controller repeating
    p_reserved_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_REPEAT && mode_code != LOOP_MODE_CODE) |=> (status == STAT_REPEAT));

    // R5: a token always ends with a received 1
    p_capture_on_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_WAIT && !rx_bit) |=> (status != STAT_SEND));

    // R7: local bits are requested only while sending
    p_req_only_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req |-> (status == STAT_SEND));

    // R8: sending ends by returning to repeating
    p_send_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_SEND) |=> (status == STAT_SEND || status == STAT_REPEAT));

endmodule

bind ring_loop_tx ring_loop_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_code (mode_code),
    .rx_bit    (rx_bit),
    .loc_req   (loc_req),
    .status    (status)
);

// File: tb/ring_loop_tx_tb_top.sv
`timescale 1ns/1ps
module ring_loop_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_code = 4'b0000;
    logic       tx_en = 1'b0;
    logic       frame_ready = 1'b0;
    logic       rx_bit = 1'b1;
    logic       loc_bit = 1'b0;
    logic       loc_last = 1'b0;
    logic       loc_req;
    logic       tx_out;
    logic [1:0] status;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic prev_rx = 1'b1;
    logic cur_rx  = 1'b1;

    always #2 clk = ~clk;

    ring_loop_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_code   (mode_code),
        .tx_en       (tx_en),
        .frame_ready (frame_ready),
        .rx_bit      (rx_bit),
        .loc_bit     (loc_bit),
        .loc_last    (loc_last),
        .loc_req     (loc_req),
        .tx_out      (tx_out),
        .status      (status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 20000) begin
            n_fail++;
            $display("FAIL watchdog R1..R9 run: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bit time: drive rx, pass the edge, sample just after it
    task automatic tick(input logic b);
        rx_bit = b;
        @(posedge clk);
        #1;
        prev_rx = cur_rx;
        cur_rx  = b;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mode_code = 4'b0000; tx_en = 1'b0; frame_ready = 1'b0;
        rx_bit = 1'b1; loc_bit = 1'b0; loc_last = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 tx_out in reset", 8'(tx_out), 8'h1);
        rst_n = 1'b1;
        prev_rx = 1'b1; cur_rx = 1'b1;
        #1;
        check("R1 status after reset", 8'(status), 8'h0);
        check("R1 loc_req after reset", 8'(loc_req), 8'h0);
        check("R1 tx_out after reset", 8'(tx_out), 8'h1);
    endtask

    task automatic t_passthrough();
        logic [15:0] pat = 16'b1001_1010_0011_0110;
        for (int i = 15; i >= 0; i--) begin
            tick(pat[i]);
            check("R2 repeat delay", 8'(tx_out), 8'(prev_rx));
        end
        check("R2 status repeating", 8'(status), 8'h0);
    endtask

    task automatic t_reserved();
        logic [3:0]  codes [2] = '{4'b1111, 4'b0110};
        logic [9:0]  seq = 10'b00_0111_1111;
        foreach (codes[c]) begin
            mode_code = codes[c]; tx_en = 1'b1; frame_ready = 1'b1;
            for (int i = 9; i >= 0; i--) begin
                tick(seq[i]);
                check("R4 reserved code repeats", 8'(tx_out), 8'(prev_rx));
                check("R4 reserved code no arm", 8'(status), 8'h0);
            end
            tick(1'b1);
            check("R4 token last bit unchanged", 8'(tx_out), 8'h1);
        end
        tx_en = 1'b0; frame_ready = 1'b0; mode_code = 4'b0000;
        tick(1'b1);
    endtask

    task automatic t_arm();
        mode_code = 4'b1110; tx_en = 1'b0; frame_ready = 1'b1;
        tick(1'b0);
        check("R3 no arm without enable", 8'(status), 8'h0);
        tx_en = 1'b1;
        tick(1'b0);
        check("R3 arm when all set", 8'(status), 8'h1);
        tick(1'b1);
        check("R3 waiting still repeats", 8'(tx_out), 8'(prev_rx));
        frame_ready = 1'b0;
        tick(1'b0);
        check("R3 disarm on frame_ready low", 8'(status), 8'h0);
        tx_en = 1'b0;
        tick(1'b0);
    endtask

    task automatic t_no_false();
        logic [7:0] near = 8'b0111_1110;
        do_reset();
        mode_code = 4'b1110; tx_en = 1'b1; frame_ready = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick(1'b1);
            if (i > 0) check("R5 ones after reset no match", 8'(status), 8'h1);
            check("R5 ones repeat", 8'(tx_out), 8'(prev_rx));
        end
        for (int i = 7; i >= 0; i--) begin
            tick(near[i]);
            check("R5 near miss no match", 8'(status), 8'h1);
            check("R5 near miss repeats", 8'(tx_out), 8'(prev_rx));
        end
        frame_ready = 1'b0; tx_en = 1'b0;
        tick(1'b0);
        tick(1'b0);
    endtask

    task automatic t_capture_frame();
        logic [7:0] tok   = 8'b0111_1111;
        logic [9:0] frame = 10'b10_1100_1001;
        logic [7:0] ga    = 8'b0111_1111;
        logic [7:0] flag_seen = '0;
        mode_code = 4'b1110; tx_en = 1'b1; frame_ready = 1'b1;
        tick(1'b0);
        tick(1'b0);
        check("R3 armed before token", 8'(status), 8'h1);
        for (int i = 7; i >= 1; i--) begin
            tick(tok[i]);
            flag_seen = {flag_seen[6:0], tx_out};
            check("R6 token prefix waits", 8'(status), 8'h1);
        end
        tick(tok[0]);
        flag_seen = {flag_seen[6:0], tx_out};
        check("R6 sending after token", 8'(status), 8'h2);
        // R9: drop enables while the frame is committed
        tx_en = 1'b0; frame_ready = 1'b0; mode_code = 4'b0000;
        tick(1'b1);
        flag_seen = {flag_seen[6:0], tx_out};
        check("R6 outgoing flag", flag_seen, 8'b0111_1110);
        check("R7 loc_req after flag", 8'(loc_req), 8'h1);
        for (int i = 9; i >= 0; i--) begin
            check("R7 loc_req during frame", 8'(loc_req), 8'h1);
            loc_bit  = frame[i];
            loc_last = (i == 0);
            tick(tok[i % 8]);
            check("R7 local bit out", 8'(tx_out), 8'(frame[i]));
            check("R9 status holds sending", 8'(status), 8'h2);
        end
        loc_last = 1'b0; loc_bit = 1'b0;
        check("R7 loc_req drops after last", 8'(loc_req), 8'h0);
        for (int k = 7; k >= 0; k--) begin
            tick(1'b0);
            check("R8 go-ahead bit", 8'(tx_out), 8'(ga[k]));
            if (k > 0) check("R8 sending during go-ahead", 8'(status), 8'h2);
        end
        check("R8 back to repeating", 8'(status), 8'h0);
        tick(1'b1);
        tick(1'b0);
        check("R8 repeat resumes", 8'(tx_out), 8'(prev_rx));
        tick(1'b1);
        check("R8 repeat resumes", 8'(tx_out), 8'(prev_rx));
        check("R1 loc_req idle", 8'(loc_req), 8'h0);
    endtask

    initial begin
        do_reset();
        t_passthrough();
        t_reserved();
        t_arm();
        t_no_false();
        t_capture_frame();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule